// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog counter behind a single 32-bit control word. Software writes the word to reload the countdown and to start or stop it. Once the watchdog has been enabled, each new write must carry a 7-bit key that is the bitwise inverse of the key stored by the previous accepted write. A write with any other key is dropped without effect. A stray store therefore cannot keep a hung system alive or switch the watchdog off.

The counter steps down once for each cycle in which `tick_en` is high. The tick source is a slow strobe of a few hundred hertz, produced outside this block. When the count runs out for the first time, the block raises a non-maskable interrupt and reloads a short grace count. If the grace count also runs out with no accepted write in between, the block issues a one-cycle reset request to the system reset logic. Any accepted write drops the interrupt and returns the escalation to its first stage.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `status` reads 0, and `nmi` and `rst_req` are low. The watchdog is disabled and the stored key is 0.
- R2: The fields of a write are placed as follows. Bits [7:0] hold the count and bit 8 holds the run command. Bits [15:9] hold the key. Bits [31:16] are ignored.
- R3: While the stored enable is 1, a write whose key is not the bitwise inverse of the stored key is discarded. It leaves `status` and `nmi` unchanged.
- R4: While the stored enable is 0, a write is accepted whatever its key. The run command and the key of that write become the stored enable and the stored key.
- R5: A count field of 0 loads 256.
- R6: An accepted write loads the count. The counter runs if the command bit is 1 and holds its value if the command bit is 0.
- R7: While running, the count falls by one on each cycle with `tick_en` high. While stopped, ticks have no effect.
- R8: The first expiry comes N ticks after a load of N. It sets `nmi` high, moves the stage to 1, and reloads the count with GRACE (default 1).
- R9: A second expiry GRACE ticks later produces a `rst_req` pulse one cycle long. It also moves the stage to 2, stops the counter with the count at 0, and keeps `nmi` high.
- R10: An accepted write clears `nmi` and returns the stage to 0, from any stage.
- R11: When a write is accepted in the same cycle as a tick, the load wins and the tick is lost.
- R12: The layout of `status` is as follows. Bits [8:0] hold the count, bit 9 the stored enable and bit 10 the running flag. Bits [12:11] hold the stage (0 armed, 1 warned, 2 fired), bits [19:13] the stored key, and the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Slow countdown strobe, one cycle per tick |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word: count, run command, key |
| nmi | output | 1 | Non-maskable interrupt level |
| rst_req | output | 1 | One-cycle system reset request |
| status | output | 32 | Count, enable, running, stage and key readback |

## Verification
The assertions check the following on every cycle. A write with the wrong key while the watchdog is enabled changes nothing. The reset request lasts exactly one cycle and only occurs while the interrupt is high. The interrupt rises only on a tick. An accepted write clears the interrupt. The count never exceeds 256 and never moves without a tick or a write. The bench scenarios cover what these checks cannot: the exact tick at which each stage fires across a sweep of load values, including the 256 case. They also cover the full sweep of rejected keys, the load taking priority over a simultaneous tick, and how the key must alternate over long chains of writes.

// File: rtl/wdg_pkg.sv
// Package wdg_pkg: shared types for the keyed watchdog.
// Assumes: the stage code is a 2-bit value visible in the status word.
package wdg_pkg;
    typedef enum logic [1:0] {
        STG_ARMED  = 2'd0,
        STG_WARNED = 2'd1,
        STG_FIRED  = 2'd2
    } wdg_stage_e;
endpackage

// File: rtl/wdg_keygate.sv
// Module wdg_keygate: holds the stored enable and key, and decides whether
// an incoming control write is accepted. It also derives the load value.
// Assumes: the count field is CNT_FIELD_W bits at the bottom, the command
// sits just above it, and the key sits above the command.
module wdg_keygate #(
    parameter int DATA_W      = 32,
    parameter int CNT_FIELD_W = 8,
    parameter int KEY_W       = 7,
    localparam int CNT_W      = CNT_FIELD_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              accept,
    output logic [CNT_W-1:0]  load_val,
    output logic              load_run,
    output logic              en_q,
    output logic [KEY_W-1:0]  key_q
);
    localparam int CMD_BIT = CNT_FIELD_W;
    localparam int KEY_LSB = CNT_FIELD_W + 1;

    logic [CNT_FIELD_W-1:0] cnt_field;
    logic [KEY_W-1:0]       wr_key;

    // Split the write into its fields.
    always_comb begin
        cnt_field = wr_data[CNT_FIELD_W-1:0];
        wr_key    = wr_data[KEY_LSB +: KEY_W];
        load_run  = wr_data[CMD_BIT];
    end

    // Key gate: open while disabled, otherwise the key must be the inverse.
    always_comb begin
        accept = wr_en && (!en_q || (wr_key == ~key_q));
    end

    // A zero count field stands for the full range.
    always_comb begin
        if (cnt_field == '0)
            load_val = CNT_W'(1) << CNT_FIELD_W;
        else
            load_val = {1'b0, cnt_field};
    end

    // Store the enable and key of each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            key_q <= '0;
        end else if (accept) begin
            en_q  <= load_run;
            key_q <= wr_key;
        end
    end
endmodule

// File: rtl/wdg_counter.sv
// Module wdg_counter: tick-driven down counter with load, grace reload and halt.
// Assumes: GRACE >= 1. The count is never 0 while running, so an expiry is
// the tick that would take the count from 1 to 0.
module wdg_counter #(
    parameter int CNT_W = 9,
    parameter int GRACE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_run,
    input  logic             reload_grace,
    output logic [CNT_W-1:0] cnt_q,
    output logic             run_q,
    output logic             expire
);
    localparam logic [CNT_W-1:0] GRACE_V = CNT_W'(GRACE);

    // Expiry: a running count of 1 meets a tick, and no load overrides it.
    always_comb begin
        expire = run_q && tick_en && (cnt_q == CNT_W'(1)) && !load;
    end

    // Count register: load first, then expiry handling, then a plain decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val;
            run_q <= load_run;
        end else if (expire) begin
            if (reload_grace) begin
                cnt_q <= GRACE_V;
            end else begin
                cnt_q <= '0;
                run_q <= 1'b0;
            end
        end else if (run_q && tick_en) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/wdg_escalate.sv
// Module wdg_escalate: two-stage escalation. The first expiry raises the
// interrupt and asks for a grace reload; the second sends a reset pulse.
// Assumes: accept and expire are never both high (a load masks the expiry).
module wdg_escalate
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic       expire,
    output logic       reload_grace,
    output logic       nmi,
    output logic       rst_req,
    output wdg_stage_e stage_q
);
    // Only an expiry in the armed stage earns a grace reload.
    always_comb begin
        reload_grace = expire && (stage_q == STG_ARMED);
    end

    // Stage, interrupt level and reset pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= STG_ARMED;
            nmi     <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            if (accept) begin
                stage_q <= STG_ARMED;
                nmi     <= 1'b0;
            end else if (expire) begin
                if (stage_q == STG_ARMED) begin
                    stage_q <= STG_WARNED;
                    nmi     <= 1'b1;
                end else begin
                    stage_q <= STG_FIRED;
                    rst_req <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/keyed_watchdog.sv
// Module keyed_watchdog: top level of the keyed two-stage watchdog.
// Assumes: tick_en is a single-cycle strobe from a slow tick generator, and
// the system reset logic acts on the rst_req pulse.
module keyed_watchdog
    import wdg_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int CNT_FIELD_W = 8,
    parameter int KEY_W       = 7,
    parameter int GRACE       = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              nmi,
    output logic              rst_req,
    output logic [DATA_W-1:0] status
);
    localparam int CNT_W   = CNT_FIELD_W + 1;
    localparam int ST_EN   = CNT_W;
    localparam int ST_RUN  = CNT_W + 1;
    localparam int ST_STG  = CNT_W + 2;
    localparam int ST_KEY  = CNT_W + 4;

    logic             accept;
    logic [CNT_W-1:0] load_val;
    logic             load_run;
    logic             en_q;
    logic [KEY_W-1:0] key_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             expire;
    logic             reload_grace;
    wdg_stage_e       stage_q;

    wdg_keygate #(
        .DATA_W      (DATA_W),
        .CNT_FIELD_W (CNT_FIELD_W),
        .KEY_W       (KEY_W)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .accept   (accept),
        .load_val (load_val),
        .load_run (load_run),
        .en_q     (en_q),
        .key_q    (key_q)
    );

    wdg_counter #(
        .CNT_W (CNT_W),
        .GRACE (GRACE)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .load         (accept),
        .load_val     (load_val),
        .load_run     (load_run),
        .reload_grace (reload_grace),
        .cnt_q        (cnt_q),
        .run_q        (run_q),
        .expire       (expire)
    );

    wdg_escalate u_esc (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .expire       (expire),
        .reload_grace (reload_grace),
        .nmi          (nmi),
        .rst_req      (rst_req),
        .stage_q      (stage_q)
    );

    // Build the status readback from the live state.
    always_comb begin
        status                  = '0;
        status[CNT_W-1:0]       = cnt_q;
        status[ST_EN]           = en_q;
        status[ST_RUN]          = run_q;
        status[ST_STG +: 2]     = stage_q;
        status[ST_KEY +: KEY_W] = key_q;
    end
endmodule

// File: rtl/wdg_checker.sv
// Module wdg_checker: port-level temporal checks for keyed_watchdog,
// attached through the bind statement at the bottom of this file.
module wdg_checker #(
    parameter int DATA_W      = 32,
    parameter int CNT_FIELD_W = 8,
    parameter int KEY_W       = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              nmi,
    input logic              rst_req,
    input logic [DATA_W-1:0] status
);
    localparam int CNT_W  = CNT_FIELD_W + 1;
    localparam int ST_EN  = CNT_W;
    localparam int ST_KEY = CNT_W + 4;

    logic bad_key;

    // A write that the key gate must refuse, judged from the ports alone.
    always_comb begin
        bad_key = wr_en && status[ST_EN] &&
                  (wr_data[CNT_FIELD_W+1 +: KEY_W] != ~status[ST_KEY +: KEY_W]);
    end

    assert_reject_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bad_key && !tick_en |=> $stable(status) && $stable(nmi));

    assert_rst_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_rst_with_nmi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> nmi);

    assert_nmi_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi) |-> $past(tick_en));

    assert_write_clears_nmi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !bad_key |=> !nmi);

    assert_count_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status[CNT_W-1:0] <= (CNT_W'(1) << CNT_FIELD_W));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en && !wr_en |=> $stable(status[CNT_W-1:0]));
endmodule

bind keyed_watchdog wdg_checker #(
    .DATA_W      (DATA_W),
    .CNT_FIELD_W (CNT_FIELD_W),
    .KEY_W       (KEY_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .nmi     (nmi),
    .rst_req (rst_req),
    .status  (status)
);

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;
    localparam int GRACE = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        nmi;
    logic        rst_req;
    logic [31:0] status;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    keyed_watchdog #(.GRACE(GRACE)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_data(wr_data), .nmi(nmi), .rst_req(rst_req), .status(status)
    );

    function automatic logic [31:0] mk(input int cnt, input bit en, input bit run,
                                       input int stg, input logic [6:0] key);
        logic [31:0] s;
        s = '0;
        s[8:0]   = 9'(cnt);
        s[9]     = en;
        s[10]    = run;
        s[12:11] = 2'(stg);
        s[19:13] = key;
        return s;
    endfunction

    function automatic logic [31:0] word(input logic [6:0] key, input bit cmd, input int cnt);
        return {16'h0, key, cmd, 8'(cnt)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_st(input string req, input logic [31:0] exp);
        chk(status === exp, req, status, exp);
    endtask

    // Tasks start and end at a falling edge.
    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog timeout actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [6:0] key;
        int exp_cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_st("R1 status", 32'h0);
        chk(nmi === 1'b0 && rst_req === 1'b0, "R1 outputs", {nmi, rst_req}, 0);

        // R4 / R6: disabled, any key accepted, hold mode
        wr(word(7'h55, 1'b0, 10));
        chk_st("R4 disabled write", mk(10, 0, 0, 0, 7'h55));
        tick(5);
        chk_st("R6 hold ignores ticks R7", mk(10, 0, 0, 0, 7'h55));

        // R2: upper bits ignored, fields placed
        wr(32'hABCD_0000 | word(7'h2A, 1'b1, 4));
        chk_st("R2 field placement R12", mk(4, 1, 1, 0, 7'h2A));
        key = 7'h2A;

        // R3: sweep every wrong key
        for (int k = 0; k < 128; k++) begin
            if (7'(k) != ~key) begin
                wr(word(7'(k), 1'b0, 9));
                chk_st("R3 wrong key rejected", mk(4, 1, 1, 0, key));
            end
        end

        // R11: write and tick together, load wins
        key = ~key;
        tick_en = 1'b1;
        wr(word(key, 1'b1, 7));
        tick_en = 1'b0;
        chk_st("R11 load beats tick", mk(7, 1, 1, 0, key));
        tick(1);
        chk_st("R7 one decrement", mk(6, 1, 1, 0, key));

        // R5 / R8 / R9 / R10: expiry sweep
        for (int idx = 0; idx < 8; idx++) begin
            int n;
            case (idx)
                0: n = 1;   1: n = 2;   2: n = 3;   3: n = 17;
                4: n = 200; 5: n = 255; 6: n = 0;   default: n = 5;
            endcase
            exp_cnt = (n == 0) ? 256 : n;
            key = ~key;
            wr(word(key, 1'b1, n));
            chk_st("R5 R6 load R10 stage cleared", mk(exp_cnt, 1, 1, 0, key));
            chk(nmi === 1'b0, "R10 nmi cleared", nmi, 0);
            tick(exp_cnt - 1);
            chk(nmi === 1'b0 && status[8:0] == 9'd1, "R8 no early expiry", status, 1);
            tick(1);
            chk(nmi === 1'b1, "R8 nmi raised", nmi, 1);
            chk_st("R8 grace stage", mk(GRACE, 1, 1, 1, key));
            if (idx % 2 == 1) begin
                key = ~key;
                wr(word(key, 1'b1, 50));
                chk(nmi === 1'b0, "R10 rescue clears nmi", nmi, 0);
                chk_st("R10 rescue stage", mk(50, 1, 1, 0, key));
            end else begin
                tick(GRACE - 1);
                chk(rst_req === 1'b0, "R9 no early reset", rst_req, 0);
                tick(1);
                chk(rst_req === 1'b1 && nmi === 1'b1, "R9 reset pulse", {rst_req, nmi}, 2'b11);
                chk_st("R9 fired stops", mk(0, 1, 0, 2, key));
                tick(3);
                chk(rst_req === 1'b0, "R9 pulse one cycle", rst_req, 0);
                chk_st("R9 stays stopped", mk(0, 1, 0, 2, key));
            end
        end

        // R4: disable with correct key, then any key is accepted
        key = ~key;
        wr(word(key, 1'b0, 30));
        chk_st("R6 disable", mk(30, 0, 0, 0, key));
        wr(word(7'h13, 1'b0, 12));
        chk_st("R4 any key after disable", mk(12, 0, 0, 0, 7'h13));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule